// File: doc/BRIEF.md
# Fractional Microsecond Tick Prescaler

This block derives a one-microsecond tick enable from a fast reference clock whose frequency need not be an integer number of megahertz. A programmable rational ratio states how many ticks must be produced across how many reference cycles. A fractional accumulator spreads those ticks evenly, so the average rate is exact even for ratios such as 64/5. Each tick is a single-cycle pulse in the reference clock domain, for use by downstream timers.

A 32-bit free-running microsecond counter advances on every tick. A small synchronous register port gives access to the ratio word, the counter value and a freeze control that stops ticks and counting. Writes are taken on the clock edge where the write enable is high. Reads are combinational from the address.

Top module: `usec_tick_gen`

## Requirements
- R1: After reset, tick_o is 0, the counter reads 0, the freeze control reads 0 and the ratio word reads the RESET_RATIO parameter (default 0x000b).
- R2: The ratio word is at offset 0x14. Bits [7:0] hold the reference-cycle count minus one (L-1). Bits [15:8] hold the tick count minus one (H-1). A write takes effect on the write edge, and a read returns the written 16 bits zero-extended.
- R3: When H <= L, the k-th clock edge after a ratio write (k >= 1) produces tick_o = floor(k*H/L) - floor((k-1)*H/L). Any L consecutive running edges therefore produce exactly H ticks.
- R4: When bits [15:8] are zero, the block divides by L: the first tick follows the L-th edge after the write, and every L-th edge after that gives another.
- R5: When H > L, the ratio saturates: every running edge produces a tick, one cycle wide at most.
- R6: Writing the ratio word clears the accumulator, so the phase restarts from zero even when the same value is written again.
- R7: The counter at offset 0x10 rises by exactly one on each tick, is unchanged otherwise, and wraps from all-ones to zero.
- R8: Writes to the counter offset are ignored: the counter value is unchanged by them.
- R9: The freeze control is bit 0 at offset 0x4c and reads back as written. While it is 1, tick_o stays 0 and the counter holds.
- R10: After freeze is cleared, counting resumes from the held value, and the next L running edges give exactly H ticks.
- R11: A read from any unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| tick_o | output | 1 | Single-cycle microsecond tick enable |

## Verification
The bench sweeps every ratio with a tick field of 0 to 7 and a cycle field of 0 to 15. Edge by edge it compares tick_o against the floor-difference formula, so an accumulator that fails to subtract, uses the wrong threshold (> instead of >=), or is not cleared on a write shows up as a tick one edge early or late. Ratios where H exceeds L catch a design that stops ticking or lets the accumulator run away. The clock ratios used in practice are checked over full windows against the counter delta. Freeze is checked for leaked ticks and counter drift, and a rewrite of an unchanged ratio is checked for a phase restart. A narrow-counter instance checks wraparound, and writes to the counter offset and unmapped reads check that the register decode is clean.

// File: rtl/usec_pkg.sv
package usec_pkg;

    localparam int RATIO_FW = 8;
    localparam int WD_W     = 2 * RATIO_FW;
    localparam int RD_W     = 32;
    localparam int ACC_W    = RATIO_FW + 2;

    localparam logic [7:0] OFF_COUNT  = 8'h10;
    localparam logic [7:0] OFF_RATIO  = 8'h14;
    localparam logic [7:0] OFF_FREEZE = 8'h4c;

    typedef struct packed {
        logic [RATIO_FW-1:0] ticks_m1;   // bits [15:8]
        logic [RATIO_FW-1:0] cycles_m1;  // bits [7:0]
    } ratio_t;

    function automatic logic [ACC_W-1:0] plus_one(input logic [RATIO_FW-1:0] v);
        return {{(ACC_W-RATIO_FW){1'b0}}, v} + ACC_W'(1);
    endfunction

endpackage

// File: rtl/usec_regs.sv
module usec_regs
    import usec_pkg::*;
#(
    parameter int          CNT_W       = 32,
    parameter int          ADDR_W      = 8,
    parameter logic [15:0] RESET_RATIO = 16'h000b
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WD_W-1:0]   wdata,
    input  logic [CNT_W-1:0]  count,
    output ratio_t            ratio,
    output logic              freeze,
    output logic              ratio_wr,
    output logic [RD_W-1:0]   rdata
);

    localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
    localparam logic [ADDR_W-1:0] A_RATIO  = ADDR_W'(OFF_RATIO);
    localparam logic [ADDR_W-1:0] A_FREEZE = ADDR_W'(OFF_FREEZE);

    ratio_t ratio_q;
    logic   freeze_q;

    assign ratio_wr = wr_en && (addr == A_RATIO);

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q  <= ratio_t'(RESET_RATIO);
            freeze_q <= 1'b0;
        end else begin
            if (ratio_wr)
                ratio_q <= ratio_t'(wdata);
            if (wr_en && (addr == A_FREEZE))
                freeze_q <= wdata[0];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_COUNT:  rdata[CNT_W-1:0] = count;
            A_RATIO:  rdata[WD_W-1:0]  = ratio_q;
            A_FREEZE: rdata[0]         = freeze_q;
            default:  rdata = '0;
        endcase
    end

    assign ratio  = ratio_q;
    assign freeze = freeze_q;

    assert_freeze_readback_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_FREEZE) |=> (freeze == $past(wdata[0])));

endmodule

// File: rtl/usec_frac_acc.sv
module usec_frac_acc
    import usec_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ratio_t ratio,
    input  logic   ratio_wr,
    input  logic   freeze,
    output logic   step,
    output logic   tick
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic [ACC_W-1:0] inc;
    logic [ACC_W-1:0] lim;
    logic [ACC_W-1:0] sum;
    logic             sat;
    logic             over;
    logic             run;
    logic             tick_q;

    always_comb begin
        inc  = plus_one(ratio.ticks_m1);
        lim  = plus_one(ratio.cycles_m1);
        sum  = acc_q + inc;
        sat  = ratio.ticks_m1 > ratio.cycles_m1;
        over = sat || (sum >= lim);
        run  = !freeze && !ratio_wr;
        step = run && over;

        if (ratio_wr)
            acc_d = '0;
        else if (freeze)
            acc_d = acc_q;
        else if (sat)
            acc_d = '0;
        else if (over)
            acc_d = sum - lim;
        else
            acc_d = sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            tick_q <= step;
        end
    end

    assign tick = tick_q;

    assert_acc_bound_R3: assert property (@(posedge clk) disable iff (rst)
        acc_q <= {{(ACC_W-RATIO_FW){1'b0}}, ratio.cycles_m1});
    assert_cfg_clears_R6: assert property (@(posedge clk) disable iff (rst)
        ratio_wr |=> (acc_q == '0));
    assert_freeze_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
        freeze |=> !tick_q);
    assert_sat_every_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (run && sat) |=> tick_q);

endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (step)
            count_q <= count_q + CNT_W'(1);
    end

    assign count = count_q;

endmodule

// File: rtl/usec_tick_gen.sv
module usec_tick_gen
    import usec_pkg::*;
#(
    parameter int          CNT_W       = 32,
    parameter int          ADDR_W      = 8,
    parameter logic [15:0] RESET_RATIO = 16'h000b
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              tick_o
);

    ratio_t           ratio;
    logic             freeze;
    logic             ratio_wr;
    logic             step;
    logic [CNT_W-1:0] count;

    usec_regs #(
        .CNT_W      (CNT_W),
        .ADDR_W     (ADDR_W),
        .RESET_RATIO(RESET_RATIO)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_wr_en),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .count   (count),
        .ratio   (ratio),
        .freeze  (freeze),
        .ratio_wr(ratio_wr),
        .rdata   (reg_rdata)
    );

    usec_frac_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .ratio   (ratio),
        .ratio_wr(ratio_wr),
        .freeze  (freeze),
        .step    (step),
        .tick    (tick_o)
    );

    usec_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .step (step),
        .count(count)
    );

    assert_count_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        tick_o |-> (count == $past(count) + CNT_W'(1)));
    assert_count_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !tick_o |-> $stable(count));

endmodule

// File: tb/usec_tick_gen_bench.sv
module usec_tick_gen_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [15:0] wdata = 16'h0;
    logic [31:0] rdata;
    logic        tick;

    logic        s_wr_en = 1'b0;
    logic [7:0]  s_addr = 8'h10;
    logic [15:0] s_wdata = 16'h0;
    logic [31:0] s_rdata;
    logic        s_tick;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    usec_tick_gen u_usec_tick_gen (
        .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .tick_o(tick)
    );

    usec_tick_gen #(.CNT_W(8)) u_small (
        .clk(clk), .rst(rst), .reg_wr_en(s_wr_en), .reg_addr(s_addr),
        .reg_wdata(s_wdata), .reg_rdata(s_rdata), .tick_o(s_tick)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic int exp_tick(input int k, input int h, input int l);
        if (h > l) return 1;
        return (k * (h + 1)) / (l + 1) - ((k - 1) * (h + 1)) / (l + 1);
    endfunction

    // R3/R4/R5: edge-by-edge pattern after a ratio write
    task automatic run_pattern(input int h, input int l, input int edges, input string req);
        wr(8'h14, {h[7:0], l[7:0]});
        for (int k = 1; k <= edges; k++) begin
            step_edge();
            chk(req, {31'b0, tick}, exp_tick(k, h, l));
        end
    endtask

    // R3/R7/R10: window of L edges gives H ticks and counter delta H
    task automatic window(input int h, input int l, input string req);
        logic [31:0] c0, c1;
        int n;
        n = 0;
        rd(8'h10, c0);
        for (int k = 0; k <= l; k++) begin
            step_edge();
            n += tick;
        end
        rd(8'h10, c1);
        chk(req, n, (h > l) ? l + 1 : h + 1);
        chk({req, "_R7"}, c1 - c0, (h > l) ? l + 1 : h + 1);
    endtask

    initial begin
        logic [31:0] v, held;
        int first;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 reset state
        chk("R1 tick", {31'b0, tick}, 0);
        rd(8'h10, v); chk("R1 count", v, 0);
        rd(8'h14, v); chk("R1 ratio", v, 32'h0000000b);
        rd(8'h4c, v); chk("R1 freeze", v, 0);

        // R2 readback, R11 unmapped
        wr(8'h14, 16'h043f);
        rd(8'h14, v); chk("R2 ratio readback", v, 32'h0000043f);
        rd(8'h20, v); chk("R11 unmapped", v, 0);
        rd(8'h00, v); chk("R11 unmapped", v, 0);

        // R3/R4/R5 sweep over small ratios
        for (int h = 0; h < 8; h++)
            for (int l = 0; l < 16; l++)
                run_pattern(h, l, 2 * (l + 1), (h == 0) ? "R4" : ((h > l) ? "R5" : "R3"));

        // R3/R4 practical ratios over full windows
        run_pattern(0, 8'h0b, 24, "R4 div12");
        window(0, 8'h0b, "R4 div12 window");
        run_pattern(0, 8'h0c, 26, "R4 div13");
        run_pattern(0, 8'h2f, 48, "R4 div48");
        run_pattern(4, 8'h3f, 128, "R3 64/5");
        window(4, 8'h3f, "R3 64/5 window");
        run_pattern(4, 8'h5f, 96, "R3 96/5");
        window(4, 8'h5f, "R3 96/5 window");
        run_pattern(4, 8'hbf, 192, "R3 192/5");
        window(4, 8'hbf, "R3 192/5 window");

        // R6 rewriting the same ratio restarts the phase
        wr(8'h14, 16'h0009);
        repeat (4) step_edge();
        wr(8'h14, 16'h0009);
        first = 0;
        for (int k = 1; k <= 10; k++) begin
            step_edge();
            if (tick && first == 0) first = k;
        end
        chk("R6 first tick after rewrite", first, 10);

        // R9 freeze, R8 counter write ignored
        wr(8'h14, 16'h043f);
        repeat (7) step_edge();
        wr(8'h4c, 16'h0001);
        rd(8'h4c, v); chk("R9 freeze readback", v, 1);
        rd(8'h10, held);
        for (int k = 0; k < 40; k++) begin
            step_edge();
            chk("R9 no tick frozen", {31'b0, tick}, 0);
        end
        rd(8'h10, v); chk("R9 count held", v, held);
        wr(8'h10, 16'hffff);
        rd(8'h10, v); chk("R8 count write ignored", v, held);

        // R10 resume
        wr(8'h4c, 16'h0000);
        rd(8'h4c, v); chk("R10 freeze cleared", v, 0);
        rd(8'h10, v); chk("R10 resumes from held", v, held);
        window(4, 8'h3f, "R10 window after resume");

        // R7 wrap on narrow counter, ratio 0x0000 ticks every edge
        @(negedge clk);
        s_wr_en = 1'b1; s_addr = 8'h14; s_wdata = 16'h0000;
        @(posedge clk);
        #1;
        s_wr_en = 1'b0; s_addr = 8'h10;
        #1;
        held = s_rdata;
        for (int k = 1; k <= 300; k++) begin
            step_edge();
            #1;
            chk("R7 narrow wrap", s_rdata, (held + k) % 256);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule